// File: doc/BRIEF.md
# Serial Result Transmitter with Tag Pass-Through

This block sends a 16-bit converter result out, most significant bit first, on one serial data line. It has two clocking modes. In the self-clocked mode, every conversion command starts a burst. The block drives its own data clock with exactly one pulse per bit and sends the result it holds at that moment, which is the result of the previous conversion. In the externally clocked mode, a receiver supplies the shift clock. Once the word has gone out, the line carries the tag input, so the serial outputs of several converters can be chained.

A conversion command is a falling edge of the logical OR of the active-low chip select and the read/convert line. The mode, the output format, the result and the tag level are all captured at that command. If a command arrives while a transfer is still running, it is held back and starts as soon as the transfer ends. All inputs are synchronous to `clk_i`. The external shift clock is oversampled by `clk_i`, so each of its levels must last at least one system clock cycle.

Top module: `result_serializer`

## Requirements
- R1: A conversion command is a high-to-low transition of (`cs_ni` OR `rd_conv_i`). A command taken with `ext_mode_i` low starts a self-clocked burst of exactly 16 pulses on `dclk_o`. Each pulse is HALF_DIV cycles low followed by HALF_DIV cycles high, and the burst begins in the cycle after the command.
- R2: `dclk_o` is low between self-clocked bursts and for the whole of an externally clocked transfer.
- R3: In a self-clocked burst, bit 15 is sent first and bit 0 last. Each bit appears on `sdata_o` at the start of its low phase and is held through the end of its high phase.
- R4: Between self-clocked bursts, `sdata_o` holds the level `tag_i` had at the command that started the last burst. It does not follow later changes of `tag_i`.
- R5: The word sent is `result_i` captured at the command. With `straight_bin_i` high it is sent unchanged. With `straight_bin_i` low its bit 15 is inverted, which gives the two's complement form.
- R6: A command taken with `ext_mode_i` high presents bit 15 from the next cycle onward. Each falling edge of `ext_clk_i` moves `sdata_o` on to the next lower bit, one cycle after that edge is seen.
- R7: After the 16th falling edge of an external transfer, `sdata_o` equals `tag_i` while `cs_ni` is low and `rd_conv_i` is high, and is 0 otherwise.
- R8: A command that arrives during a transfer is held in one pending slot and starts in the cycle after the current transfer ends. A newer command that arrives before then replaces the pending one.
- R9: During and after reset, before any command, `sdata_o` and `dclk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1: external shift clock, 0: self-clocked bursts |
| straight_bin_i | input | 1 | 1: straight binary, 0: two's complement |
| cs_ni | input | 1 | Chip select, active low |
| rd_conv_i | input | 1 | Read/convert; ORed with `cs_ni` to form the command |
| tag_i | input | 1 | Tag bit sent after or between words |
| ext_clk_i | input | 1 | External shift clock, data advance on its falling edge |
| result_i | input | 16 | Latched conversion result (straight binary) |
| sdata_o | output | 1 | Serial data |
| dclk_o | output | 1 | Generated data clock |

## Verification
A reference model in the bench runs alongside the design and predicts both outputs every cycle. Separately, the bench rebuilds each word from the data bit seen at every generated rising edge.

Two self-clocked bursts use different words and tag levels, once in each format, which distinguishes a wrong bit order from a wrong format inversion. A train of three commands that overlap a running burst shows whether the pending slot keeps the newest request and whether it starts without loss. One burst is started by chip select instead of read/convert, which proves the OR of the two lines. An external transfer with an asymmetric word, followed by tag toggles under each combination of select lines, separates the shift path from the pass-through gating.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_EXT = 1'b1
  } rs_mode_e;
endpackage

// File: rtl/rs_edge.sv
module rs_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= RST_VAL;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/rs_pace.sv
module rs_pace #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic hi_o,
  output logic bit_end_o
);
  localparam int unsigned TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [TW-1:0] tmr_q;
  logic          hi_q;
  logic          wrap;

  assign wrap = (tmr_q == TW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      hi_q  <= 1'b0;
    end else if (restart_i) begin
      tmr_q <= '0;
      hi_q  <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        tmr_q <= '0;
        hi_q  <= ~hi_q;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign hi_o      = hi_q;
  // end of a high phase closes one bit
  assign bit_end_o = run_i & hi_q & wrap;
endmodule

// File: rtl/rs_shift.sv
module rs_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              adv_i,
  output logic              msb_o,
  output logic              at_last_o
);
  localparam int unsigned CW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= '0;
    end else if (adv_i) begin
      sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign msb_o     = sh_q[WORD_W-1];
  assign at_last_o = (cnt_q == CW'(WORD_W - 1));
endmodule

// File: rtl/rs_pend.sv
module rs_pend #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tag_i,
  input  rs_pkg::rs_mode_e  mode_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              tag_o,
  output rs_pkg::rs_mode_e  mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      tag_o   <= 1'b0;
      mode_o  <= rs_pkg::MODE_INT;
    end else if (push_i) begin
      valid_o <= 1'b1;
      word_o  <= word_i;
      tag_o   <= tag_i;
      mode_o  <= mode_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/result_serializer.sv
module result_serializer #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic              straight_bin_i,
  input  logic              cs_ni,
  input  logic              rd_conv_i,
  input  logic              tag_i,
  input  logic              ext_clk_i,
  input  logic [WORD_W-1:0] result_i,
  output logic              sdata_o,
  output logic              dclk_o
);
  import rs_pkg::*;

  logic              cmd_w, ext_fall;
  logic              active_q, tag_q;
  rs_mode_e          mode_q, live_mode;
  logic [WORD_W-1:0] live_word, src_word, pend_word;
  logic              pend_valid, pend_tag, src_tag;
  rs_mode_e          pend_mode, src_mode;
  logic              int_run, ext_run, hi_w, bit_end, adv_w, at_last, msb_w;
  logic              end_w, free_w, take_cmd, start_w, push_w, pop_w;

  rs_edge #(.RST_VAL(1'b1)) i_cmd_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(cs_ni | rd_conv_i), .fall_o(cmd_w)
  );
  rs_edge #(.RST_VAL(1'b0)) i_clk_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(ext_clk_i), .fall_o(ext_fall)
  );

  assign live_word = {result_i[WORD_W-1] ^ ~straight_bin_i, result_i[WORD_W-2:0]};
  assign live_mode = ext_mode_i ? MODE_EXT : MODE_INT;

  assign int_run  = active_q & (mode_q == MODE_INT);
  assign ext_run  = active_q & (mode_q == MODE_EXT);
  assign adv_w    = (int_run & bit_end) | (ext_run & ext_fall);
  assign end_w    = adv_w & at_last;
  assign free_w   = ~active_q | end_w;
  assign take_cmd = free_w & ~pend_valid & cmd_w;
  assign start_w  = free_w & (pend_valid | cmd_w);
  assign push_w   = cmd_w & ~take_cmd;
  assign pop_w    = start_w & pend_valid;

  assign src_word = pend_valid ? pend_word : live_word;
  assign src_tag  = pend_valid ? pend_tag  : tag_i;
  assign src_mode = pend_valid ? pend_mode : live_mode;

  rs_pend #(.WORD_W(WORD_W)) i_pend (
    .clk_i (clk_i), .rst_ni(rst_ni), .push_i(push_w), .pop_i(pop_w),
    .word_i(live_word), .tag_i(tag_i), .mode_i(live_mode),
    .valid_o(pend_valid), .word_o(pend_word), .tag_o(pend_tag), .mode_o(pend_mode)
  );

  rs_pace #(.HALF_DIV(HALF_DIV)) i_pace (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(int_run), .restart_i(start_w),
    .hi_o  (hi_w), .bit_end_o(bit_end)
  );

  rs_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(start_w), .word_i(src_word),
    .adv_i (adv_w), .msb_o(msb_w), .at_last_o(at_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mode_q   <= MODE_INT;
      tag_q    <= 1'b0;
    end else if (start_w) begin
      active_q <= 1'b1;
      mode_q   <= src_mode;
      tag_q    <= src_tag;
    end else if (end_w) begin
      active_q <= 1'b0;
    end
  end

  assign dclk_o = int_run & hi_w;

  always_comb begin
    if (active_q)                sdata_o = msb_w;
    else if (mode_q == MODE_INT) sdata_o = tag_q;
    else                         sdata_o = ~cs_ni & rd_conv_i & tag_i;
  end
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dclk_o,
  input logic             sdata_o,
  input logic             active_q,
  input rs_pkg::rs_mode_e mode_q,
  input logic             start_w,
  input logic             end_w
);
  logic       dclk_prev;
  logic [7:0] rises;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_prev <= 1'b0;
      rises     <= '0;
    end else begin
      dclk_prev <= dclk_o;
      if (start_w)                rises <= '0;
      else if (dclk_o & ~dclk_prev) rises <= rises + 1'b1;
    end
  end

  AST_PULSES_PER_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_w && mode_q == rs_pkg::MODE_INT) |-> (rises == 8'(WORD_W))); // R1
  AST_DCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q || mode_q == rs_pkg::MODE_EXT) |-> !dclk_o); // R2
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dclk_o && $past(dclk_o)) |-> $stable(sdata_o)); // R3
  AST_DATA_STABLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dclk_o) |-> $stable(sdata_o)); // R3
  AST_TAG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && mode_q == rs_pkg::MODE_INT && $past(!active_q) &&
     $past(mode_q == rs_pkg::MODE_INT)) |-> $stable(sdata_o)); // R4
endmodule

bind result_serializer rs_checker #(.WORD_W(WORD_W)) i_rs_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .dclk_o  (dclk_o),
  .sdata_o (sdata_o),
  .active_q(active_q),
  .mode_q  (mode_q),
  .start_w (start_w),
  .end_w   (end_w)
);

// File: tb/test_result_serializer.sv
`timescale 1ns/1ps
module test_result_serializer;
  localparam int H = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_mode = 1'b0, sb = 1'b1, cs_n = 1'b0, rd = 1'b1, tag = 1'b1, eclk = 1'b0;
  logic [15:0] result = 16'hA5C3;
  logic sdata, dclk;

  int checks = 0, failures = 0;
  string phase = "R9";

  always #2 clk = ~clk;

  result_serializer #(.WORD_W(16), .HALF_DIV(H)) i_result_serializer (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .straight_bin_i(sb),
    .cs_ni(cs_n), .rd_conv_i(rd), .tag_i(tag), .ext_clk_i(eclk),
    .result_i(result), .sdata_o(sdata), .dclk_o(dclk)
  );

  // behavioural reference
  logic        m_pc, m_pe, m_act, m_ext, m_tag;
  logic [15:0] m_word;
  int          m_t, m_nf;
  logic [17:0] m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 1'b1; m_pe = 1'b0; m_act = 1'b0; m_ext = 1'b0; m_tag = 1'b0;
      m_word = '0; m_t = 0; m_nf = 0; m_q.delete();
    end else begin
      logic cmd, fall, fin, cn;
      logic [17:0] e;
      cn = cs_n | rd;
      cmd = m_pc && !cn; m_pc = cn;
      fall = m_pe && !eclk; m_pe = eclk;
      fin = 1'b0;
      if (m_act) begin
        if (!m_ext) begin m_t++; if (m_t == 32*H) fin = 1'b1; end
        else if (fall) begin m_nf++; if (m_nf == 16) fin = 1'b1; end
      end
      if (fin) m_act = 1'b0;
      if (cmd) begin
        e = {ext_mode, tag, sb ? result : (result ^ 16'h8000)};
        if (m_act && m_q.size() == 1) m_q[0] = e;
        else m_q.push_back(e);
      end
      if (!m_act && m_q.size() > 0) begin
        e = m_q.pop_front();
        m_act = 1'b1; m_ext = e[17]; m_word = e[15:0]; m_t = 0; m_nf = 0;
        if (!e[17]) m_tag = e[16];
      end
    end
  end

  task automatic fail(string req, string what, int act, int exp);
    failures++;
    $display("FAIL %s (phase %s) %s actual=%0h expected=%0h", req, phase, what, act, exp);
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  // per-cycle compare, plus word capture at each generated rising edge
  logic        dclk_seen = 1'b0;
  int          rise_cnt = 0;
  logic [15:0] cap = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic ed, es;
      string rq;
      ed = m_act && !m_ext && ((m_t % (2*H)) >= H);
      if (m_act && !m_ext)      begin es = m_word[15 - m_t/(2*H)]; rq = "R3"; end
      else if (m_act)           begin es = m_word[15 - m_nf];      rq = "R6"; end
      else if (!m_ext)          begin es = m_tag;                  rq = "R4"; end
      else                      begin es = !cs_n && rd && tag;     rq = "R7"; end
      check(m_ext ? "R2" : "R1", "dclk", dclk, ed);
      check(rq, "sdata", sdata, es);
      if (dclk && !dclk_seen) begin rise_cnt++; cap = {cap[14:0], sdata}; end
      dclk_seen = dclk;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmd_rd();
    rd = 1'b0; step(2); rd = 1'b1; step(1);
  endtask

  initial begin
    step(3);
    check("R9", "sdata in reset", sdata, 0);
    check("R9", "dclk in reset", dclk, 0);
    rst_n = 1'b1;
    step(4);
    check("R9", "sdata after reset", sdata, 0);
    check("R9", "dclk after reset", dclk, 0);

    // straight binary burst
    phase = "R1"; rise_cnt = 0;
    cmd_rd(); step(70);
    check("R1", "pulse count", rise_cnt, 16);
    check("R3", "captured word", cap, 16'hA5C3);
    check("R4", "tag between bursts", sdata, 1);
    tag = 1'b0; step(3);
    check("R4", "tag held after change", sdata, 1);

    // two's complement burst
    phase = "R5"; sb = 1'b0; result = 16'h1234; rise_cnt = 0;
    cmd_rd(); step(70);
    check("R5", "two's complement word", cap, 16'h9234);
    check("R4", "tag low held", sdata, 0);

    // queued and overwritten commands
    phase = "R8"; sb = 1'b1; result = 16'h0F0F; tag = 1'b1; rise_cnt = 0;
    cmd_rd(); step(20);
    result = 16'hF00F; tag = 1'b0; cmd_rd(); step(10);
    result = 16'h3C3C; tag = 1'b1; cmd_rd();
    result = 16'h0000; tag = 1'b0;
    step(150);
    check("R8", "pulses over two bursts", rise_cnt, 32);
    check("R8", "queued word is newest", cap, 16'h3C3C);
    check("R8", "tag of queued command", sdata, 1);

    // command from chip select
    phase = "R1"; result = 16'h00FF; rise_cnt = 0;
    cs_n = 1'b1; rd = 1'b0; step(2);
    cs_n = 1'b0; step(2); rd = 1'b1; step(70);
    check("R1", "chip-select started burst", rise_cnt, 16);
    check("R1", "chip-select burst word", cap, 16'h00FF);

    // external clock
    phase = "R6"; ext_mode = 1'b1; result = 16'hC001; rise_cnt = 0;
    cmd_rd();
    begin
      logic [15:0] ecap = '0;
      for (int i = 0; i < 16; i++) begin
        eclk = 1'b1; step(3);
        ecap = {ecap[14:0], sdata};
        eclk = 1'b0; step(3);
      end
      check("R6", "external word", ecap, 16'hC001);
    end
    check("R2", "no generated pulses in external mode", rise_cnt, 0);
    phase = "R7";
    tag = 1'b1; step(2); check("R7", "tag pass high", sdata, 1);
    tag = 1'b0; step(2); check("R7", "tag pass low", sdata, 0);
    tag = 1'b1; cs_n = 1'b1; step(2); check("R7", "deselected", sdata, 0);
    rd = 1'b0; step(2); check("R7", "read/convert low", sdata, 0);
    rd = 1'b1; cs_n = 1'b0; step(2); check("R7", "reselected", sdata, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule